// File: doc/BRIEF.md
# Segmented Boundary-Scan Register for a Dual 9-Bit Transceiver

This block is the boundary-scan data register wrapped around a two-channel, 9-bit-per-channel bidirectional transceiver. Each channel has an A side and a B side, a direction input and an active-low gate input. Observe-only cells watch the pins the transceiver receives, including the direction and gate inputs. Observe-and-control cells, each with an update latch, sit on the data the transceiver drives and on the two internal active-high enables per channel, one for the A side and one for the B side.

The external test controller provides capture, shift and update strobes on the test clock and a few decoded mode lines. One mode line picks how much of the register sits between the serial input and the serial output: all 80 cells, the 40 observing cells alone, or the 40 driving cells alone. A drive-select line hands the pin data and enables from the system transceiver logic over to the update latches. The block also holds the system transceiver path: direction low sends B to A, direction high sends A to B, and a high gate turns both sides off.

Top module: `bsr_segmented`

## Requirements
- R1: With no segment selected, the chain holds 80 cells with cell 0 next to `tdo`. Cells 0–8 drive channel-2 A, 9–17 drive channel-1 A, 18–26 watch channel-2 B, 27–35 watch channel-1 B, 36–44 drive channel-2 B, 45–53 drive channel-1 B, 54–62 watch channel-2 A and 63–71 watch channel-1 A. Inside each 9-cell group the lowest cell holds lane 8. Cells 72..79 are channel-2 B enable, channel-2 A enable, channel-2 gate, channel-2 direction, channel-1 B enable, channel-1 A enable, channel-1 gate and channel-1 direction.
- R2: With `segIn` high, only the 40 observing cells (the data inputs, gates and directions) form the chain, in ascending cell order, so cell 18 sits at `tdo`. `segIn` wins over `segOut`.
- R3: With `segOut` high and `segIn` low, only the 40 driving cells (the data outputs and the enables) form the chain, in ascending cell order.
- R4: A capture loads each cell of the selected chain. Observing cells take their pin. A driving data cell takes the system value: the A data of a channel equals that channel's B pins lane for lane, and the B data equals its A pins. An enable cell takes its system enable.
- R5: An update latch changes only on an update strobe, and only when its cell is in the selected chain. It then takes the shift-stage value.
- R6: With `testDrive` high, pin data and enables come from the update latches. With it low, they come from the system path.
- R7: In the system path, a channel's A enable is high when its gate and direction are both low. Its B enable is high when its gate is low and its direction is high. The A and B enables of a channel are never high together.
- R8: An enable latch holding 1 activates its side in test drive, and a latch holding 0 leaves that side off.
- R9: With `bsrSel` low, capture, shift and update strobes leave the shift stages and the latches unchanged.
- R10: Reset clears every shift stage and every update latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Active-low asynchronous reset |
| bsrSel | input | 1 | The boundary register is the selected data register |
| segIn | input | 1 | Observing-cell segment only |
| segOut | input | 1 | Driving-cell segment only |
| testDrive | input | 1 | Pins driven from the update latches |
| captureDr | input | 1 | Capture strobe |
| shiftDr | input | 1 | Shift strobe |
| updateDr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| aPinIn | input | 2×BYTE_W | A-side pin values, index 0 = channel 1 |
| bPinIn | input | 2×BYTE_W | B-side pin values |
| dirIn | input | 2 | Direction per channel, high = A to B |
| gN | input | 2 | Active-low gate per channel |
| aPinOut | output | 2×BYTE_W | Data driven on the A side |
| bPinOut | output | 2×BYTE_W | Data driven on the B side |
| aOe | output | 2 | A-side drive enable per channel |
| bOe | output | 2 | B-side drive enable per channel |

## Verification
The hardest state to reach is a segment update that must leave the latches outside the segment alone. To get there, the bench loads every latch through the full chain and turns on test drive so the latches appear on the pins. It then captures, shifts and updates in the other segment and compares the pins before and after. Segment length is shown by shifting a known pattern in and reading it back out after exactly 40 or 80 more clocks. Strobes with `bsrSel` low are checked the same way, through the pins and a later shift-out.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    CHAIN_FULL = 2'd0,
    CHAIN_IN   = 2'd1,
    CHAIN_OUT  = 2'd2
  } chainCfg_t;

  // Roles 0..3 are the data groups in ascending pairs, 4..7 the control quartet.
  typedef enum logic [2:0] {
    ROLE_A_OUT = 3'd0,
    ROLE_B_IN  = 3'd1,
    ROLE_B_OUT = 3'd2,
    ROLE_A_IN  = 3'd3,
    ROLE_BOE   = 3'd4,
    ROLE_AOE   = 3'd5,
    ROLE_GATE  = 3'd6,
    ROLE_DIR   = 3'd7
  } cellRole_t;

  typedef struct packed {
    logic      capture;
    logic      shift;
    logic      update;
    logic      testDrive;
    chainCfg_t cfg;
  } scanStrobe_t;

  function automatic cellRole_t roleOf(int w, int idx);
    if (idx < 8 * w) return cellRole_t'(3'(idx / (2 * w)));
    return cellRole_t'(3'(4 + ((idx - 8 * w) % 4)));
  endfunction

  // Channel index 0 is channel 1; even data groups and the low control quartet are channel 2.
  function automatic int chanOf(int w, int idx);
    if (idx < 8 * w) return (((idx / w) % 2) == 0) ? 1 : 0;
    return ((idx - 8 * w) < 4) ? 1 : 0;
  endfunction

  function automatic int laneOf(int w, int idx);
    return w - 1 - (idx % w);
  endfunction

  function automatic int indexOf(int w, cellRole_t r, int ch, int lane);
    if (r < ROLE_BOE) return (int'(r) * 2 + ((ch == 1) ? 0 : 1)) * w + (w - 1 - lane);
    return 8 * w + ((ch == 1) ? 0 : 4) + (int'(r) - 4);
  endfunction

  function automatic bit hasLatch(cellRole_t r);
    return r inside {ROLE_A_OUT, ROLE_B_OUT, ROLE_BOE, ROLE_AOE};
  endfunction

  function automatic bit inSegment(chainCfg_t c, cellRole_t r);
    case (c)
      CHAIN_IN:  return !hasLatch(r);
      CHAIN_OUT: return hasLatch(r);
      default:   return 1'b1;
    endcase
  endfunction

  // Nearest member above idx; 8w+8 stands for the serial input.
  function automatic int nextMember(int w, chainCfg_t c, int idx);
    int res;
    res = 8 * w + 8;
    for (int j = 8 * w + 7; j > idx; j--)
      if (inSegment(c, roleOf(w, j))) res = j;
    return res;
  endfunction

  function automatic int firstMember(int w, chainCfg_t c);
    int res;
    res = 0;
    for (int j = 8 * w + 7; j >= 0; j--)
      if (inSegment(c, roleOf(w, j))) res = j;
    return res;
  endfunction

endpackage

// File: rtl/bsr_control.sv
module bsr_control
  import bsr_pkg::*;
(
  input  logic        bsrSel,
  input  logic        segIn,
  input  logic        segOut,
  input  logic        testDrive,
  input  logic        captureDr,
  input  logic        shiftDr,
  input  logic        updateDr,
  output scanStrobe_t strobe
);

  always_comb begin
    strobe.capture   = bsrSel & captureDr;
    strobe.shift     = bsrSel & shiftDr & ~captureDr;
    strobe.update    = bsrSel & updateDr & ~captureDr & ~shiftDr;
    strobe.testDrive = testDrive;
    if (segIn)       strobe.cfg = CHAIN_IN;
    else if (segOut) strobe.cfg = CHAIN_OUT;
    else             strobe.cfg = CHAIN_FULL;
  end

endmodule

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int BYTE_W = 9
) (
  input  logic                   tck,
  input  logic                   trstN,
  input  scanStrobe_t            strobe,
  input  logic                   tdi,
  output logic                   tdo,
  input  logic [1:0][BYTE_W-1:0] aPinIn,
  input  logic [1:0][BYTE_W-1:0] bPinIn,
  input  logic [1:0]             dirIn,
  input  logic [1:0]             gN,
  output logic [1:0][BYTE_W-1:0] aPinOut,
  output logic [1:0][BYTE_W-1:0] bPinOut,
  output logic [1:0]             aOe,
  output logic [1:0]             bOe
);

  localparam int LEN   = 8 * BYTE_W + 8;
  localparam int TDO_F = firstMember(BYTE_W, CHAIN_FULL);
  localparam int TDO_I = firstMember(BYTE_W, CHAIN_IN);
  localparam int TDO_O = firstMember(BYTE_W, CHAIN_OUT);

  logic [LEN-1:0] shiftQ;
  logic [LEN-1:0] updQ;
  logic [LEN-1:0] chainExt;
  logic [1:0]     sysAOe;
  logic [1:0]     sysBOe;

  // System transceiver enables
  assign sysAOe = ~gN & ~dirIn;
  assign sysBOe = ~gN & dirIn;

  // chainExt[k] feeds a cell whose source is k+1; the top entry is the serial input.
  assign chainExt = {tdi, shiftQ[LEN-1:1]};

  for (genvar i = 0; i < LEN; i++) begin : gCell
    localparam cellRole_t ROLE = roleOf(BYTE_W, i);
    localparam int CH    = chanOf(BYTE_W, i);
    localparam int SRC_F = nextMember(BYTE_W, CHAIN_FULL, i);
    localparam int SRC_I = nextMember(BYTE_W, CHAIN_IN, i);
    localparam int SRC_O = nextMember(BYTE_W, CHAIN_OUT, i);
    localparam bit IN_I  = inSegment(CHAIN_IN, ROLE);
    localparam bit IN_O  = inSegment(CHAIN_OUT, ROLE);

    logic capBit;
    logic shiftIn;
    logic member;
    logic cellQ;

    case (ROLE)
      ROLE_A_OUT: begin : gCap
        localparam int LANE = laneOf(BYTE_W, i);
        assign capBit = bPinIn[CH][LANE];
      end
      ROLE_B_OUT: begin : gCap
        localparam int LANE = laneOf(BYTE_W, i);
        assign capBit = aPinIn[CH][LANE];
      end
      ROLE_A_IN: begin : gCap
        localparam int LANE = laneOf(BYTE_W, i);
        assign capBit = aPinIn[CH][LANE];
      end
      ROLE_B_IN: begin : gCap
        localparam int LANE = laneOf(BYTE_W, i);
        assign capBit = bPinIn[CH][LANE];
      end
      ROLE_DIR:  begin : gCap assign capBit = dirIn[CH];  end
      ROLE_GATE: begin : gCap assign capBit = gN[CH];     end
      ROLE_AOE:  begin : gCap assign capBit = sysAOe[CH]; end
      default:   begin : gCap assign capBit = sysBOe[CH]; end
    endcase

    always_comb begin
      case (strobe.cfg)
        CHAIN_IN: begin
          member  = IN_I;
          shiftIn = chainExt[SRC_I-1];
        end
        CHAIN_OUT: begin
          member  = IN_O;
          shiftIn = chainExt[SRC_O-1];
        end
        default: begin
          member  = 1'b1;
          shiftIn = chainExt[SRC_F-1];
        end
      endcase
    end

    always_ff @(posedge tck or negedge trstN) begin
      if (!trstN)                         cellQ <= 1'b0;
      else if (member && strobe.capture)  cellQ <= capBit;
      else if (member && strobe.shift)    cellQ <= shiftIn;
    end
    assign shiftQ[i] = cellQ;

    if (hasLatch(ROLE)) begin : gLatch
      logic latchQ;
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN)                       latchQ <= 1'b0;
        else if (member && strobe.update) latchQ <= cellQ;
      end
      assign updQ[i] = latchQ;
    end else begin : gNoLatch
      assign updQ[i] = 1'b0;
    end
  end

  always_comb begin
    case (strobe.cfg)
      CHAIN_IN:  tdo = shiftQ[TDO_I];
      CHAIN_OUT: tdo = shiftQ[TDO_O];
      default:   tdo = shiftQ[TDO_F];
    endcase
  end

  // Pin mux between system path and update latches
  for (genvar ch = 0; ch < 2; ch++) begin : gChan
    localparam int IDX_AOE = indexOf(BYTE_W, ROLE_AOE, ch, 0);
    localparam int IDX_BOE = indexOf(BYTE_W, ROLE_BOE, ch, 0);
    assign aOe[ch] = strobe.testDrive ? updQ[IDX_AOE] : sysAOe[ch];
    assign bOe[ch] = strobe.testDrive ? updQ[IDX_BOE] : sysBOe[ch];
    for (genvar l = 0; l < BYTE_W; l++) begin : gLane
      localparam int IDX_A = indexOf(BYTE_W, ROLE_A_OUT, ch, l);
      localparam int IDX_B = indexOf(BYTE_W, ROLE_B_OUT, ch, l);
      assign aPinOut[ch][l] = strobe.testDrive ? updQ[IDX_A] : bPinIn[ch][l];
      assign bPinOut[ch][l] = strobe.testDrive ? updQ[IDX_B] : aPinIn[ch][l];
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    !strobe.update |=> $stable(updQ)); // R5

  AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    (!strobe.capture && !strobe.shift) |=> $stable(shiftQ)); // R9

  AST_FULL_SHIFT: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.shift && strobe.cfg == CHAIN_FULL) |=> (shiftQ[0] == $past(shiftQ[1]))); // R1

  AST_SEG_IN_CAPTURE: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.capture && strobe.cfg == CHAIN_IN) |=> (shiftQ[LEN-1] == $past(dirIn[0]))); // R4

  AST_SYS_ONE_SIDE: assert property (@(posedge tck) disable iff (!trstN)
    !strobe.testDrive |-> (!(aOe[0] && bOe[0]) && !(aOe[1] && bOe[1]))); // R7

endmodule

// File: rtl/bsr_segmented.sv
module bsr_segmented
  import bsr_pkg::*;
#(
  parameter int BYTE_W = 9
) (
  input  logic                   tck,
  input  logic                   trstN,
  input  logic                   bsrSel,
  input  logic                   segIn,
  input  logic                   segOut,
  input  logic                   testDrive,
  input  logic                   captureDr,
  input  logic                   shiftDr,
  input  logic                   updateDr,
  input  logic                   tdi,
  output logic                   tdo,
  input  logic [1:0][BYTE_W-1:0] aPinIn,
  input  logic [1:0][BYTE_W-1:0] bPinIn,
  input  logic [1:0]             dirIn,
  input  logic [1:0]             gN,
  output logic [1:0][BYTE_W-1:0] aPinOut,
  output logic [1:0][BYTE_W-1:0] bPinOut,
  output logic [1:0]             aOe,
  output logic [1:0]             bOe
);

  scanStrobe_t strobe;

  bsr_control u_control (
    .bsrSel    (bsrSel),
    .segIn     (segIn),
    .segOut    (segOut),
    .testDrive (testDrive),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .strobe    (strobe)
  );

  bsr_datapath #(.BYTE_W(BYTE_W)) u_datapath (
    .tck     (tck),
    .trstN   (trstN),
    .strobe  (strobe),
    .tdi     (tdi),
    .tdo     (tdo),
    .aPinIn  (aPinIn),
    .bPinIn  (bPinIn),
    .dirIn   (dirIn),
    .gN      (gN),
    .aPinOut (aPinOut),
    .bPinOut (bPinOut),
    .aOe     (aOe),
    .bOe     (bOe)
  );

endmodule

// File: tb/bsr_segmented_bench.sv
module bsr_segmented_bench;

  localparam int W = 9;

  logic clk = 1'b0;
  logic trstN = 1'b0;
  logic bsrSel = 1'b0, segIn = 1'b0, segOut = 1'b0, testDrive = 1'b0;
  logic captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [1:0][W-1:0] aIn = '0, bIn = '0, aOut, bOut;
  logic [1:0] dirIn = '0, gN = '0, aOe, bOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bsr_segmented #(.BYTE_W(W)) u_bsr_segmented (
    .tck(clk), .trstN(trstN), .bsrSel(bsrSel), .segIn(segIn), .segOut(segOut),
    .testDrive(testDrive), .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .tdi(tdi), .tdo(tdo), .aPinIn(aIn), .bPinIn(bIn), .dirIn(dirIn), .gN(gN),
    .aPinOut(aOut), .bPinOut(bOut), .aOe(aOe), .bOe(bOe)
  );

  // {a, b, dir, gN, expected aOe, expected bOe}
  localparam logic [43:0] VEC [6] = '{
    {18'h3FFFF, 18'h00F0F, 2'b00, 2'b00, 2'b11, 2'b00},
    {18'h00000, 18'h3C3C3, 2'b11, 2'b00, 2'b00, 2'b11},
    {18'h15555, 18'h12345, 2'b01, 2'b00, 2'b10, 2'b01},
    {18'h0AAAA, 18'h3FFFF, 2'b10, 2'b01, 2'b00, 2'b10},
    {18'h2468A, 18'h00001, 2'b00, 2'b11, 2'b00, 2'b00},
    {18'h13579, 18'h20000, 2'b11, 2'b10, 2'b00, 2'b01}
  };

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] rv(input logic [8:0] x);
    logic [8:0] r;
    for (int k = 0; k < 9; k++) r[k] = x[8-k];
    return r;
  endfunction

  function automatic logic [79:0] fullModel(input logic [1:0][8:0] a, input logic [1:0][8:0] b,
                                            input logic [1:0] d, input logic [1:0] g);
    logic [1:0] ao, bo;
    ao = ~g & ~d;
    bo = ~g & d;
    return {d[0], g[0], ao[0], bo[0], d[1], g[1], ao[1], bo[1],
            rv(a[0]), rv(a[1]), rv(a[0]), rv(a[1]), rv(b[0]), rv(b[1]), rv(b[0]), rv(b[1])};
  endfunction

  function automatic logic [39:0] inModel(input logic [1:0][8:0] a, input logic [1:0][8:0] b,
                                          input logic [1:0] d, input logic [1:0] g);
    return {d[0], g[0], d[1], g[1], rv(a[0]), rv(a[1]), rv(b[0]), rv(b[1])};
  endfunction

  function automatic logic [39:0] outModel(input logic [1:0][8:0] a, input logic [1:0][8:0] b,
                                           input logic [1:0] d, input logic [1:0] g);
    logic [1:0] ao, bo;
    ao = ~g & ~d;
    bo = ~g & d;
    return {ao[0], bo[0], ao[1], bo[1], rv(a[0]), rv(a[1]), rv(b[0]), rv(b[1])};
  endfunction

  task automatic shiftBits(input int n, input logic [79:0] din, output logic [79:0] dout);
    dout = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      shiftDr = 1'b1;
      tdi = din[k];
      #1;
      dout[k] = tdo;
    end
    @(negedge clk);
    shiftDr = 1'b0;
  endtask

  task automatic doCapture();
    @(negedge clk); captureDr = 1'b1;
    @(negedge clk); captureDr = 1'b0;
  endtask

  task automatic doUpdate();
    @(negedge clk); updateDr = 1'b1;
    @(negedge clk); updateDr = 1'b0;
  endtask

  task automatic checkPins(input string req, input logic [17:0] ea, input logic [17:0] eb,
                           input logic [1:0] eao, input logic [1:0] ebo);
    #1;
    check(req, 80'(aOut), 80'(ea));
    check(req, 80'(bOut), 80'(eb));
    check(req, 80'(aOe), 80'(eao));
    check(req, 80'(bOe), 80'(ebo));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [79:0] got, pat, fullVec;
    logic [39:0] segVec;
    logic [39:0] outPat;

    // R10: reset state seen through test drive and an unloaded shift-out
    repeat (3) @(negedge clk);
    trstN = 1'b1;
    testDrive = 1'b1;
    checkPins("R10 reset latches", '0, '0, 2'b00, 2'b00);
    bsrSel = 1'b1;
    shiftBits(80, '0, got);
    check("R10 reset shift stages", got, '0);

    // R7 / R6: system path table, test drive off
    testDrive = 1'b0;
    for (int r = 0; r < 6; r++) begin
      @(negedge clk);
      {aIn, bIn, dirIn, gN} = VEC[r][43:4];
      checkPins("R7 R6 system path", bIn, aIn, VEC[r][3:2], VEC[r][1:0]);
    end

    // R1 / R4: full chain capture and shift-out
    aIn = 18'h2A5C3; bIn = 18'h1B4E7; dirIn = 2'b01; gN = 2'b00;
    pat = 80'hA5F03C961E87D24B5A69;
    doCapture();
    shiftBits(80, pat, got);
    check("R4 R1 full capture", got, fullModel(aIn, bIn, dirIn, gN));

    // R5 / R6 / R8: full update, then latches on the pins
    doUpdate();
    testDrive = 1'b1;
    checkPins("R5 R6 R8 full update", {rv(pat[8:0]), rv(pat[17:9])},
              {rv(pat[44:36]), rv(pat[53:45])}, {pat[73], pat[77]}, {pat[72], pat[76]});

    // R1: chain length is 80
    shiftBits(80, '0, got);
    check("R1 full length", got, pat);

    // R9: strobes ignored with bsrSel low
    bsrSel = 1'b0;
    shiftBits(40, {80{1'b1}}, got);
    doCapture();
    doUpdate();
    checkPins("R9 latches kept", {rv(pat[8:0]), rv(pat[17:9])},
              {rv(pat[44:36]), rv(pat[53:45])}, {pat[73], pat[77]}, {pat[72], pat[76]});
    bsrSel = 1'b1;
    shiftBits(80, '0, got);
    check("R9 shift stages kept", got, '0);

    // R2 / R4: input segment
    segIn = 1'b1;
    segOut = 1'b1;  // R2: input segment wins over output segment
    aIn = 18'h0F0F0; bIn = 18'h35A5A; dirIn = 2'b10; gN = 2'b01;
    doCapture();
    shiftBits(40, 80'h5A3C96E1F0, got);
    segVec = inModel(aIn, bIn, dirIn, gN);
    check("R2 R4 input segment capture", got, 80'(segVec));
    doUpdate();
    checkPins("R5 input segment leaves latches", {rv(pat[8:0]), rv(pat[17:9])},
              {rv(pat[44:36]), rv(pat[53:45])}, {pat[73], pat[77]}, {pat[72], pat[76]});
    shiftBits(40, '0, got);
    check("R2 input segment length", got, 80'h5A3C96E1F0);

    // R3 / R4: output segment
    segIn = 1'b0;
    aIn = 18'h1C3A5; bIn = 18'h2E6D1; dirIn = 2'b00; gN = 2'b10;
    outPat = 40'h96C3A5F00F;
    doCapture();
    shiftBits(40, 80'(outPat), got);
    segVec = outModel(aIn, bIn, dirIn, gN);
    check("R3 R4 output segment capture", got, 80'(segVec));
    doUpdate();
    checkPins("R3 R5 R8 output segment update", {rv(outPat[8:0]), rv(outPat[17:9])},
              {rv(outPat[26:18]), rv(outPat[35:27])}, {outPat[37], outPat[39]},
              {outPat[36], outPat[38]});
    shiftBits(40, '0, got);
    check("R3 output segment length", got, 80'(outPat));

    // R6: test drive off hands pins back to the system path
    testDrive = 1'b0;
    checkPins("R6 system path restored", bIn, aIn, 2'b01, 2'b00);

    // R1: full chain back, capture of the current pins
    segOut = 1'b0;
    doCapture();
    shiftBits(80, '0, got);
    fullVec = fullModel(aIn, bIn, dirIn, gN);
    check("R1 R4 full capture again", got, fullVec);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule